// File: doc/BRIEF.md
# Supervised Reset Delay Generator

This block drives the active-low main reset of a baseband processor from the state of two supply rails and a phone-on indication. It watches a power-good flag for the I/O rail and one for the memory rail. Both flags are brought into the clock domain through a two-flop synchronizer. A delay counter starts once the I/O rail reports good. The reset line is released only when three conditions hold together: the counter has reached its programmed target, both rails are good, and the phone is on.

The delay is set by a unit count multiplied by a fixed number of clock cycles per unit, so the release time scales linearly with the programmed value. The reset line drops again whenever either rail loses regulation or the phone is switched off. Any dropout, even a single cycle long, throws away the elapsed time, and the full delay must run again before the next release. The output comes straight from a flop whose reset value is low, so it cannot glitch.

Top module: `supv_reset_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycles right after it, `rst_n_o` is low.
- R2: With `phone_on` high, when `io_pg` and `mem_pg` rise together and then stay high, `rst_n_o` rises at the 3+N-th rising clock edge after the change, where N = `delay_units` × CYCLES_PER_UNIT (4 by default).
- R3: A `delay_units` value of 0 releases `rst_n_o` at the third rising edge after both rails become good, with no added delay.
- R4: When `io_pg` falls, `rst_n_o` is low after the third rising edge. Once `io_pg` returns, the full delay is timed again, giving 3+N edges from its return.
- R5: A dropout of `mem_pg` lasting a single cycle drives `rst_n_o` low by the third edge and restarts the delay. `rst_n_o` rises again at edge 4+N, counted from the start of the dropout.
- R6: The delay counts while only the I/O rail is good. If the memory rail becomes good after the delay has elapsed, `rst_n_o` stays low until then and rises at the third edge after `mem_pg` rises.
- R7: When `phone_on` is low, `rst_n_o` is low after the next rising edge and stays low. When `phone_on` returns with both rails good, the delay is timed from zero and `rst_n_o` rises at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_pg | input | 1 | I/O rail power-good flag, asynchronous |
| mem_pg | input | 1 | Memory rail power-good flag, asynchronous |
| phone_on | input | 1 | Phone-on indication, synchronous |
| delay_units | input | UNIT_W (8) | Programmed delay in units of CYCLES_PER_UNIT clocks |
| rst_n_o | output | 1 | Registered active-low main reset |

## Verification
Some properties are checked on every cycle by assertions. The reset line is low in the cycle after a rail is seen missing, after the phone is off, and after the block reset. A memory-rail dropout clears the counter, and the counter only ever clears or advances by one. The bench scenarios are needed for the exact release latency for several delay values, including zero. They also show the full restart after a one-cycle dropout, the timer running on the I/O rail alone, and the restart after the phone is turned back on.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Synchronized rail status carried between stages
    typedef struct packed {
        logic io;
        logic mem;
    } rails_t;

    localparam int unsigned RAIL_COUNT = $bits(rails_t);

    // Width needed to hold units * cycles_per_unit
    function automatic int unsigned target_width(input int unsigned unit_w,
                                                 input int unsigned cyc_per_unit);
        return unit_w + $clog2(cyc_per_unit + 1);
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[b]};
                end
            end
            assign q_sync[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
    parameter int unsigned UNIT_W        = 8,
    parameter int unsigned CYCLES_PER_UNIT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  phone_on,
    input  supv_rst_pkg::rails_t  rails,
    input  logic [UNIT_W-1:0]     delay_units,
    output logic                  done
);
    import supv_rst_pkg::*;

    localparam int unsigned TGT_W = target_width(UNIT_W, CYCLES_PER_UNIT);
    localparam logic [TGT_W-1:0] CPU_V = TGT_W'(CYCLES_PER_UNIT);

    logic [TGT_W-1:0] target;
    logic [TGT_W-1:0] cnt;
    logic             mem_q;
    logic             mem_fall;
    logic             clear;
    logic             run;

    assign target   = TGT_W'(delay_units) * CPU_V;
    assign mem_fall = mem_q && !rails.mem;
    assign clear    = !phone_on || !rails.io || mem_fall;
    assign run      = phone_on && rails.io;
    assign done     = (cnt >= target);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= 1'b0;
        end else begin
            mem_q <= rails.mem;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && (cnt < target)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a memory-rail drop empties the counter
    p_mem_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_q && !rails.mem) |=> (cnt == '0));

    // R2: counter only clears or steps by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == '0) || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int unsigned UNIT_W          = 8,
    parameter int unsigned CYCLES_PER_UNIT = 4,
    parameter int unsigned SYNC_STAGES     = supv_rst_pkg::SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_pg,
    input  logic              mem_pg,
    input  logic              phone_on,
    input  logic [UNIT_W-1:0] delay_units,
    output logic              rst_n_o
);
    import supv_rst_pkg::*;

    logic [RAIL_COUNT-1:0] rails_raw;
    logic [RAIL_COUNT-1:0] rails_syn;
    rails_t                rails;
    logic                  tmr_done;
    logic                  rst_n_q;

    assign rails_raw = {io_pg, mem_pg};

    pg_sync #(
        .W      (RAIL_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rails_raw),
        .q_sync  (rails_syn)
    );

    assign rails = rails_t'(rails_syn);

    delay_timer #(
        .UNIT_W          (UNIT_W),
        .CYCLES_PER_UNIT (CYCLES_PER_UNIT)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .phone_on    (phone_on),
        .rails       (rails),
        .delay_units (delay_units),
        .done        (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_q <= 1'b0;
        end else begin
            rst_n_q <= phone_on && rails.io && rails.mem && tmr_done;
        end
    end

    assign rst_n_o = rst_n_q;

    // R1: held low by the block reset
    p_low_after_reset_r1: assert property (@(posedge clk)
        rst |=> !rst_n_o);

    // R4: a missing rail forces the line low on the next edge
    p_rail_loss_low_r4: assert property (@(posedge clk) disable iff (rst)
        !(rails.io && rails.mem) |=> !rst_n_o);

    // R7: phone off keeps the line low
    p_phone_off_low_r7: assert property (@(posedge clk) disable iff (rst)
        !phone_on |=> !rst_n_o);

    // R2: a release only follows a completed delay
    p_release_after_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && !$past(rst_n_o)) |-> $past(tmr_done));

endmodule

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;

    localparam int unsigned UNIT_W = 8;
    localparam int unsigned CPU    = 4;

    typedef struct {
        int    start;
        int    lat;
        string req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              io_pg = 1'b0;
    logic              mem_pg = 1'b0;
    logic              phone_on = 1'b0;
    logic [UNIT_W-1:0] delay_units = '0;
    logic              rst_n_o;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    logic prev_rn = 1'b0;
    exp_t sb[$];

    supv_reset_gen #(
        .UNIT_W          (UNIT_W),
        .CYCLES_PER_UNIT (CPU)
    ) u_supv_reset_gen (
        .clk         (clk),
        .rst         (rst),
        .io_pg       (io_pg),
        .mem_pg      (mem_pg),
        .phone_on    (phone_on),
        .delay_units (delay_units),
        .rst_n_o     (rst_n_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_low(input string req);
        n_tests++;
        if (rst_n_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: rst_n_o actual %b expected 0 at cycle %0d", req, rst_n_o, cyc);
        end
    endtask

    // Driver side: push the expected release latency, counted from now
    task automatic expect_release(input int lat, input string req);
        exp_t e;
        e.start = cyc;
        e.lat   = lat;
        e.req   = req;
        sb.push_back(e);
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (sb.size() != 0 && t < 300) begin
            step(1);
            t++;
        end
        if (sb.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL %s: release never seen, actual pending %0d expected 0", req, sb.size());
            sb.delete();
        end
    endtask

    task automatic drop_all();
        io_pg  = 1'b0;
        mem_pg = 1'b0;
        step(6);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: pop an expectation on each observed release
    always @(negedge clk) begin
        if (rst_n_o === 1'b1 && prev_rn !== 1'b1) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected release: actual rise at cycle %0d expected none", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (cyc - e.start != e.lat) begin
                    n_fail++;
                    $display("FAIL %s: release latency actual %0d expected %0d",
                             e.req, cyc - e.start, e.lat);
                end
            end
        end
        prev_rn = rst_n_o;
    end

    // Watchdog
    initial begin
        wait (cyc > 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected finish before 20000", cyc);
        report();
    end

    initial begin
        step(3);
        check_low("R1");
        rst = 1'b0;
        step(2);
        check_low("R1");

        phone_on = 1'b1;
        step(5);
        check_low("R4");

        // R2: unit value 1
        delay_units = 8'd1;
        expect_release(3 + 1 * CPU, "R2");
        io_pg  = 1'b1;
        mem_pg = 1'b1;
        wait_drain("R2");

        // R4: I/O rail loss and full restart
        step(2);
        io_pg = 1'b0;
        step(3);
        check_low("R4");
        step(5);
        check_low("R4");
        expect_release(3 + 1 * CPU, "R4");
        io_pg = 1'b1;
        wait_drain("R4");

        // R2: unit value 5
        drop_all();
        delay_units = 8'd5;
        expect_release(3 + 5 * CPU, "R2");
        io_pg  = 1'b1;
        mem_pg = 1'b1;
        wait_drain("R2");

        // R3: zero delay
        drop_all();
        delay_units = 8'd0;
        expect_release(3, "R3");
        io_pg  = 1'b1;
        mem_pg = 1'b1;
        wait_drain("R3");

        // R5: one-cycle memory dropout
        drop_all();
        delay_units = 8'd2;
        expect_release(3 + 2 * CPU, "R2");
        io_pg  = 1'b1;
        mem_pg = 1'b1;
        wait_drain("R2");
        step(3);
        expect_release(4 + 2 * CPU, "R5");
        mem_pg = 1'b0;
        step(1);
        mem_pg = 1'b1;
        step(2);
        check_low("R5");
        wait_drain("R5");

        // R6: timer runs on the I/O rail alone
        drop_all();
        io_pg = 1'b1;
        step(3 + 2 * CPU + 10);
        check_low("R6");
        expect_release(3, "R6");
        mem_pg = 1'b1;
        wait_drain("R6");

        // R7: phone off, then back on
        step(2);
        phone_on = 1'b0;
        step(1);
        check_low("R7");
        step(12);
        check_low("R7");
        expect_release(1 + 2 * CPU, "R7");
        phone_on = 1'b1;
        wait_drain("R7");

        step(5);
        n_tests++;
        if (rst_n_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R7: rst_n_o actual %b expected 1 after settle", rst_n_o);
        end

        report();
    end

endmodule